// File: doc/BRIEF.md
# Sprite list scanner

This block walks a table of sprite attribute entries once per video frame and turns each entry into a decoded descriptor for a downstream sprite line renderer. A single-cycle frame-start pulse begins the walk. The block then reads the entries one by one, in ascending index order, through a synchronous read port. Each read returns one 32-bit word holding the four bytes of an entry.

For every entry the block builds a 9-bit vertical and horizontal position from a low byte and a ninth bit in the attribute byte. It subtracts the sprite scroll offsets from these positions. It then mirrors the horizontal result about a fixed base. It also forms a 10-bit tile code, whose two bank bits have opposite polarity, and a 4-bit colour. The scroll offsets are a fixed bias plus an 8-bit scroll register, plus 256 when a selected bit of a shared control register is set.

Descriptors leave through a ready/valid handshake. When the consumer holds ready low, the current descriptor is kept as it is. A done flag marks that the whole list has been handed over.

Top module: `spr_list_scan`

## Requirements
- R1: After reset, desc_valid, scan_done, scan_busy and rd_en are all low.
- R2: A frame_start pulse while idle starts a scan. The scan reads entries 0 to 59 in ascending order, with read data arriving on rd_data one cycle after rd_en. It yields exactly one descriptor per entry in that order. Nothing is read while idle.
- R3: Each read word carries four byte lanes: bits 7:0 Y low, bits 15:8 tile low, bits 23:16 X low, bits 31:24 attribute. desc_color equals attribute bits 3:0.
- R4: desc_tile equals the tile low byte, plus 512 when attribute bit 5 is clear, plus 256 when attribute bit 6 is set.
- R5: The Y position is the Y low byte with attribute bit 4 as its ninth bit. desc_y equals that position minus (9 + scroll_y + 256 when scroll_ctl bit 3 is set), modulo 512. The other bits of scroll_ctl have no effect.
- R6: The X position is the X low byte with attribute bit 7 as its ninth bit. desc_x equals 256 minus (that position minus (30 + scroll_x + 256 when scroll_ctl bit 0 is set)), modulo 512.
- R7: While desc_valid is high and desc_ready is low, desc_valid stays high and all descriptor fields stay unchanged. No entry is skipped.
- R8: A frame_start pulse during a scan is ignored. The scan continues from its current entry and still delivers all 60 descriptors once each.
- R9: scan_done rises after the 60th descriptor is accepted. It stays high while idle and is cleared by the next frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Single-cycle pulse that begins a scan |
| scroll_x | input | 8 | Horizontal sprite scroll register |
| scroll_y | input | 8 | Vertical sprite scroll register |
| scroll_ctl | input | 8 | Shared control register; bit 0 is the X scroll ninth bit, bit 3 is the Y scroll ninth bit |
| rd_en | output | 1 | Read strobe to the attribute table |
| rd_addr | output | 6 | Entry index being read |
| rd_data | input | 32 | Entry word, valid one cycle after rd_en |
| desc_valid | output | 1 | Descriptor valid |
| desc_ready | input | 1 | Descriptor accepted by the consumer |
| desc_x | output | 9 | Mirrored, scrolled X position |
| desc_y | output | 9 | Scrolled Y position |
| desc_tile | output | 10 | Tile code |
| desc_color | output | 4 | Colour code |
| scan_busy | output | 1 | A scan is in progress |
| scan_done | output | 1 | The last scan has finished |

## Verification
The assertions assume three things about the inputs:
- The table answers a read in exactly the next cycle.
- frame_start is a single-cycle pulse.
- The scroll and control registers are steady for the whole time a descriptor is being built.

The bench keeps to these assumptions. Its table model registers rd_data on the clock edge that samples rd_en. It raises frame_start for one cycle only. It changes the scroll values and table contents only between scans, after scan_done is seen.

// File: rtl/spr_scan_pkg.sv
package spr_scan_pkg;

   localparam int BYTE_W  = 8;
   localparam int ENTRY_W = 4 * BYTE_W;
   localparam int POS_W   = BYTE_W + 1;
   localparam int TILE_W  = BYTE_W + 2;
   localparam int COL_W   = 4;

   typedef struct packed {
      logic [POS_W-1:0]  xpos;
      logic [POS_W-1:0]  ypos;
      logic [TILE_W-1:0] tile;
      logic [COL_W-1:0]  color;
   } spr_desc_t;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_READ,
      SQ_LOAD,
      SQ_HOLD
   } seq_state_e;

endpackage

// File: rtl/spr_scan_seq.sv
module spr_scan_seq
   import spr_scan_pkg::*;
#(
   parameter int N_ENTRIES = 60,
   parameter int IDX_W     = $clog2(N_ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             out_accept,
   output logic             rd_en,
   output logic [IDX_W-1:0] rd_idx,
   output logic             load_en,
   output logic             busy,
   output logic             done
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

   seq_state_e       state;
   logic [IDX_W-1:0] idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         idx   <= '0;
         done  <= 1'b0;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (frame_start) begin
                  state <= SQ_READ;
                  idx   <= '0;
                  done  <= 1'b0;
               end
            end
            SQ_READ: state <= SQ_LOAD;
            SQ_LOAD: state <= SQ_HOLD;
            SQ_HOLD: begin
               if (out_accept) begin
                  if (idx == LAST_IDX) begin
                     state <= SQ_IDLE;
                     done  <= 1'b1;
                  end else begin
                     idx   <= idx + 1'b1;
                     state <= SQ_READ;
                  end
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign rd_en   = (state == SQ_READ);
   assign load_en = (state == SQ_LOAD);
   assign busy    = (state != SQ_IDLE);
   assign rd_idx  = idx;

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (rd_idx <= LAST_IDX)) else $error("index past end"); // R2

   AST_FIRST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(state) == SQ_IDLE) |-> (rd_idx == '0)) else $error("scan not from 0"); // R2

   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(state) == SQ_HOLD) |-> (rd_idx == IDX_W'($past(rd_idx) + 1'b1)))
      else $error("index not ascending"); // R2

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && frame_start && !out_accept) |=> (busy && rd_idx == $past(rd_idx)))
      else $error("restart during scan"); // R8

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !frame_start) |=> done) else $error("done dropped"); // R9

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy) else $error("done while busy"); // R9

endmodule

// File: rtl/spr_entry_decode.sv
module spr_entry_decode
   import spr_scan_pkg::*;
#(
   parameter int X_BIAS      = 30,
   parameter int Y_BIAS      = 9,
   parameter int MIRROR_BASE = 256,
   parameter bit MIRROR_X    = 1'b1
) (
   input  logic [ENTRY_W-1:0] entry,
   input  logic [BYTE_W-1:0]  scroll_x,
   input  logic [BYTE_W-1:0]  scroll_y,
   input  logic               scroll_xhi,
   input  logic               scroll_yhi,
   output spr_desc_t          desc
);

   // byte lanes of an entry word
   localparam int LANE_Y = 0;
   localparam int LANE_T = 1;
   localparam int LANE_X = 2;
   localparam int LANE_A = 3;
   // attribute bit roles
   localparam int A_YHI  = 4;
   localparam int A_BKN  = 5;   // active low: adds 512
   localparam int A_BKP  = 6;   // active high: adds 256
   localparam int A_XHI  = 7;

   logic [BYTE_W-1:0] y_lo, t_lo, x_lo, attr;
   logic [POS_W-1:0]  x_pos, y_pos, x_scr, y_scr, x_rel, y_rel, x_out;

   assign y_lo = entry[LANE_Y*BYTE_W +: BYTE_W];
   assign t_lo = entry[LANE_T*BYTE_W +: BYTE_W];
   assign x_lo = entry[LANE_X*BYTE_W +: BYTE_W];
   assign attr = entry[LANE_A*BYTE_W +: BYTE_W];

   assign x_pos = {attr[A_XHI], x_lo};
   assign y_pos = {attr[A_YHI], y_lo};

   assign x_scr = POS_W'(X_BIAS) + POS_W'(scroll_x) + {scroll_xhi, {BYTE_W{1'b0}}};
   assign y_scr = POS_W'(Y_BIAS) + POS_W'(scroll_y) + {scroll_yhi, {BYTE_W{1'b0}}};

   assign x_rel = x_pos - x_scr;
   assign y_rel = y_pos - y_scr;

   generate
      if (MIRROR_X) begin : g_mirror
         assign x_out = POS_W'(MIRROR_BASE) - x_rel;
      end else begin : g_plain
         assign x_out = x_rel;
      end
   endgenerate

   always_comb begin
      desc.xpos  = x_out;
      desc.ypos  = y_rel;
      desc.tile  = {~attr[A_BKN], attr[A_BKP], t_lo};
      desc.color = attr[COL_W-1:0];
   end

endmodule

// File: rtl/spr_desc_reg.sv
module spr_desc_reg
   import spr_scan_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load_en,
   input  spr_desc_t desc_in,
   input  logic      out_ready,
   output logic      out_valid,
   output spr_desc_t desc_q,
   output logic      accept
);

   assign accept = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         desc_q    <= '0;
      end else if (load_en) begin
         out_valid <= 1'b1;
         desc_q    <= desc_in;
      end else if (accept) begin
         out_valid <= 1'b0;
      end
   end

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(desc_q)))
      else $error("descriptor changed under stall"); // R7

   AST_LOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |-> !out_valid) else $error("load over pending descriptor"); // R7

endmodule

// File: rtl/spr_list_scan.sv
module spr_list_scan
   import spr_scan_pkg::*;
#(
   parameter int N_ENTRIES   = 60,
   parameter int X_BIAS      = 30,
   parameter int Y_BIAS      = 9,
   parameter int MIRROR_BASE = 256,
   parameter bit MIRROR_X    = 1'b1,
   parameter int CTL_XHI     = 0,
   parameter int CTL_YHI     = 3,
   parameter int IDX_W       = $clog2(N_ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_start,
   input  logic [BYTE_W-1:0]  scroll_x,
   input  logic [BYTE_W-1:0]  scroll_y,
   input  logic [BYTE_W-1:0]  scroll_ctl,
   output logic               rd_en,
   output logic [IDX_W-1:0]   rd_addr,
   input  logic [ENTRY_W-1:0] rd_data,
   output logic               desc_valid,
   input  logic               desc_ready,
   output logic [POS_W-1:0]   desc_x,
   output logic [POS_W-1:0]   desc_y,
   output logic [TILE_W-1:0]  desc_tile,
   output logic [COL_W-1:0]   desc_color,
   output logic               scan_busy,
   output logic               scan_done
);

   generate
      if (N_ENTRIES < 2 || N_ENTRIES > 256) begin : g_bad_depth
         $error("spr_list_scan: N_ENTRIES must lie in 2..256");
      end
      if (CTL_XHI < 0 || CTL_XHI >= BYTE_W || CTL_YHI < 0 || CTL_YHI >= BYTE_W) begin : g_bad_ctl
         $error("spr_list_scan: control bit index outside the register");
      end
      if (MIRROR_BASE < 0 || MIRROR_BASE >= (1 << POS_W)) begin : g_bad_mirror
         $error("spr_list_scan: MIRROR_BASE outside the position range");
      end
   endgenerate

   logic      load_en, accept;
   spr_desc_t dec_desc, out_desc;
   logic      ctl_unused;

   assign ctl_unused = ^scroll_ctl;

   spr_scan_seq #(
      .N_ENTRIES (N_ENTRIES),
      .IDX_W     (IDX_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .out_accept  (accept),
      .rd_en       (rd_en),
      .rd_idx      (rd_addr),
      .load_en     (load_en),
      .busy        (scan_busy),
      .done        (scan_done)
   );

   spr_entry_decode #(
      .X_BIAS      (X_BIAS),
      .Y_BIAS      (Y_BIAS),
      .MIRROR_BASE (MIRROR_BASE),
      .MIRROR_X    (MIRROR_X)
   ) u_dec (
      .entry      (rd_data),
      .scroll_x   (scroll_x),
      .scroll_y   (scroll_y),
      .scroll_xhi (scroll_ctl[CTL_XHI]),
      .scroll_yhi (scroll_ctl[CTL_YHI]),
      .desc       (dec_desc)
   );

   spr_desc_reg u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (load_en),
      .desc_in   (dec_desc),
      .out_ready (desc_ready),
      .out_valid (desc_valid),
      .desc_q    (out_desc),
      .accept    (accept)
   );

   assign desc_x     = out_desc.xpos;
   assign desc_y     = out_desc.ypos;
   assign desc_tile  = out_desc.tile;
   assign desc_color = out_desc.color;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_busy |-> (!desc_valid && !rd_en)) else $error("activity while idle"); // R2

endmodule

// File: tb/spr_list_scan_bench.sv
module spr_list_scan_bench;
   import spr_scan_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int N  = 60;
   localparam int AW = $clog2(N);
   localparam int NV = 6;

   // {scroll_x, scroll_y, scroll_ctl, entry word, expected {x,y,tile,colour}}
   localparam logic [87:0] VEC [NV] = '{
      {8'h00, 8'h00, 8'h00, 32'h00000000, 9'h11E, 9'h1F7, 10'h200, 4'h0},
      {8'h10, 8'h20, 8'h09, 32'hF540AB80, 9'h0EE, 9'h057, 10'h1AB, 4'h5},
      {8'hFF, 8'hFF, 8'h00, 32'h4AFF1210, 9'h11E, 9'h108, 10'h312, 4'hA},
      {8'h00, 8'h00, 8'hF6, 32'h2F1E0009, 9'h100, 9'h000, 10'h000, 4'hF},
      {8'hE2, 8'hF7, 8'h09, 32'h9000FF00, 9'h000, 9'h100, 10'h2FF, 4'h0},
      {8'h01, 8'h02, 8'h01, 32'h138055F0, 9'h19F, 9'h1E5, 10'h255, 4'h3}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_start = 1'b0;
   logic desc_ready = 1'b0;
   logic [7:0] scroll_x = '0, scroll_y = '0, scroll_ctl = '0;
   logic rd_en;
   logic [AW-1:0] rd_addr;
   logic [31:0] rd_data;
   logic desc_valid, scan_busy, scan_done;
   logic [8:0] desc_x, desc_y;
   logic [9:0] desc_tile;
   logic [3:0] desc_color;

   logic [31:0] mem [N];
   logic [31:0] exp_arr [N];
   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_ff @(posedge clk) begin
      if (rd_en) rd_data <= mem[rd_addr];
   end

   spr_list_scan u_spr_list_scan (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .scroll_x(scroll_x), .scroll_y(scroll_y), .scroll_ctl(scroll_ctl),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .desc_valid(desc_valid), .desc_ready(desc_ready),
      .desc_x(desc_x), .desc_y(desc_y), .desc_tile(desc_tile), .desc_color(desc_color),
      .scan_busy(scan_busy), .scan_done(scan_done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // expected descriptor from the requirements (R3..R6)
   function automatic logic [31:0] model(input logic [31:0] w, input logic [7:0] sx,
                                         input logic [7:0] sy, input logic [7:0] ctl);
      int xp, yp, xs, ys, x, y;
      logic [9:0] t;
      yp = {23'd0, w[28], w[7:0]};
      xp = {23'd0, w[31], w[23:16]};
      ys = 9 + int'(sy) + (ctl[3] ? 256 : 0);
      xs = 30 + int'(sx) + (ctl[0] ? 256 : 0);
      y  = (yp - ys) & 511;
      x  = (256 - (xp - xs)) & 511;
      t  = {~w[29], w[30], w[15:8]};
      return {x[8:0], y[8:0], t, w[27:24]};
   endfunction

   // stall_mode 0: ready always; 1: ready one cycle in three; 2: ready low for 8 cycles then high
   task automatic run_scan(input int stall_mode, input int poke_at, input string req);
      int k = 0;
      int cyc = 0;
      bit held_v = 1'b0;
      logic [31:0] held = '0;
      logic [31:0] cur;
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      chk(scan_done == 1'b0, "R9", "done cleared by start", {31'd0, scan_done}, 32'd0);
      while (!scan_done && cyc < 4000) begin
         case (stall_mode)
            0:       desc_ready = 1'b1;
            1:       desc_ready = ((cyc % 3) == 2);
            default: desc_ready = (cyc >= 8);
         endcase
         #1;
         cur = {desc_x, desc_y, desc_tile, desc_color};
         if (held_v)
            chk(desc_valid && cur == held, "R7", "held under stall", cur, held);
         if (desc_valid && desc_ready) begin
            if (k < N) chk(cur == exp_arr[k], req, $sformatf("entry %0d", k), cur, exp_arr[k]);
            else chk(1'b0, "R2", "extra descriptor", k, N);
            k++;
            if (k == poke_at) frame_start = 1'b1;
         end
         held_v = desc_valid && !desc_ready;
         held   = cur;
         @(negedge clk);
         frame_start = 1'b0;
         cyc++;
      end
      chk(k == N, "R2 R8 R9", "descriptors before done", k, N);
      chk(!desc_valid && !scan_busy, "R9", "idle after done", {desc_valid, scan_busy}, 0);
      desc_ready = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int idle_reads;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!desc_valid && !scan_done && !scan_busy && !rd_en, "R1", "reset state",
          {desc_valid, scan_done, scan_busy, rd_en}, 0);

      idle_reads = 0;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (rd_en || desc_valid) idle_reads++;
      end
      chk(idle_reads == 0, "R2", "no activity while idle", idle_reads, 0);

      // table walk: R3 R4 R5 R6
      for (int v = 0; v < NV; v++) begin
         scroll_x   = VEC[v][87:80];
         scroll_y   = VEC[v][79:72];
         scroll_ctl = VEC[v][71:64];
         for (int i = 0; i < N; i++) begin
            mem[i]     = VEC[v][63:32];
            exp_arr[i] = VEC[v][31:0];
         end
         run_scan(v % 2, 0, "R3 R4 R5 R6");
      end

      // done held while idle (R9)
      repeat (10) @(negedge clk);
      chk(scan_done && !scan_busy && !rd_en, "R9", "done sticky",
          {scan_done, scan_busy, rd_en}, 3'b100);

      // per-entry contents: ascending order, stalls, ignored restart (R2 R7 R8)
      scroll_x = 8'h5A; scroll_y = 8'hC3; scroll_ctl = 8'h08;
      for (int i = 0; i < N; i++) begin
         mem[i]     = 32'(i) * 32'h9E3779B1 + 32'h01234567;
         exp_arr[i] = model(mem[i], scroll_x, scroll_y, scroll_ctl);
      end
      run_scan(1, 5, "R2 R8");
      run_scan(2, 0, "R2 R7");

      scroll_x = 8'h07; scroll_y = 8'h80; scroll_ctl = 8'h01;
      for (int i = 0; i < N; i++) begin
         mem[i]     = ~(32'(i) * 32'h85EBCA6B) ^ 32'(i << 24);
         exp_arr[i] = model(mem[i], scroll_x, scroll_y, scroll_ctl);
      end
      run_scan(0, 59, "R2 R5 R6 R8");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule